// File: doc/BRIEF.md
# Temperature Event Comparator

This block watches a stream of signed temperature samples and raises an active-low event line when a sample crosses limits that software has programmed. Three limits are kept: a high and a low limit that form a window, and a critical limit with its own release hysteresis. Each sample is compared only when its valid strobe is high. Three status flags report the result of the most recent sample: above the high limit, below the low limit, and the critical state.

Software picks one of three event modes. In latched mode, a window violation sets a pending event that stays set until software writes the clear bit. In window mode, the event follows the status flags and releases by itself. In critical-only mode, the window is ignored and only the critical state drives the event. The critical state drives the event in every mode as a self-releasing comparator, and a clear write cannot release it.

Top module: `temp_alarm_unit`

## Requirements
- R1: After a synchronous active-low reset, event_n is 1 and all three flags are 0. The limits reset to high = largest positive code, low = most negative code, critical = largest positive code and hysteresis = 0. The mode resets to window (code 1).
- R2: A write with reg_we high stores reg_wdata at the active edge. Address 0 holds the high limit, 1 the low limit, 2 the critical limit, 3 the unsigned critical hysteresis and 4 the mode in bits [1:0]. Address 5 is the control word, where a write with bit 0 = 1 clears the pending event.
- R3: Samples are taken only on edges where temp_vld is 1. On any other edge, the flags and the pending event keep their values.
- R4: flag_above_hi is set when the sample is strictly greater than the high limit. flag_below_lo is set when the sample is strictly less than the low limit. Samples equal to either limit set neither flag. Both comparisons are signed two's complement.
- R5: The critical flag sets when a sample is strictly greater than the critical limit. It clears only when a sample is strictly less than the critical limit minus the hysteresis. Between those two points it keeps its value.
- R6: In window mode (code 1; code 3 behaves the same), event_n is 0 exactly while at least one of the three flags is 1.
- R7: In latched mode (code 0), a sample outside the window sets a pending event that holds event_n at 0. The pending event stays set through later in-window samples until a clear write.
- R8: The critical flag drives event_n to 0 in every mode. A clear write while the critical flag is 1 leaves event_n at 0.
- R9: In critical-only mode (code 2), only the critical flag drives event_n. Window flags still update but do not assert the event.
- R10: Writing any mode other than latched discards a pending event at that same edge.
- R11: All outputs come from registers and change at the edge that takes the sample or write. They are stable for the whole following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_vld | input | 1 | Sample valid strobe |
| temp_val | input | 11 | Signed temperature sample |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 11 | Register write data |
| event_n | output | 1 | Active-low event |
| flag_above_hi | output | 1 | Last sample above high limit |
| flag_below_lo | output | 1 | Last sample below low limit |
| flag_crit | output | 1 | Critical state with hysteresis |

## Verification
A wrong critical state shows at the ports in one of two ways. Either event_n stays low after a sample that has dropped below the release threshold, or it goes high while the sample sits inside the hysteresis band. Either error is visible in the cycle after that sample. A pending event that is lost or stuck shows in latched mode as event_n going high before the clear write, or staying low after it. The bench walks each limit with samples at, just above and just below the threshold, so that an off-by-one comparison changes a flag within one cycle.

// File: rtl/tevt_pkg.sv
// Package: shared mode encoding and register addresses for the
// temperature event comparator. Assumes a 3-bit register address.
package tevt_pkg;
    typedef enum logic [1:0] {
        EVM_LATCH    = 2'd0,
        EVM_WINDOW   = 2'd1,
        EVM_CRITONLY = 2'd2,
        EVM_WINDOW2  = 2'd3
    } evt_mode_e;

    localparam int unsigned RA_HIGH = 0;
    localparam int unsigned RA_LOW  = 1;
    localparam int unsigned RA_CRIT = 2;
    localparam int unsigned RA_HYST = 3;
    localparam int unsigned RA_MODE = 4;
    localparam int unsigned RA_CTRL = 5;
endpackage

// File: rtl/tevt_regs.sv
// Module: tevt_regs
// Holds the programmable limits, hysteresis and mode. It also decodes the
// one-cycle clear and mode-leave strobes. Assumes writes are single-cycle
// pulses and that the address fits the map in tevt_pkg.
module tevt_regs
    import tevt_pkg::*;
#(
    parameter int TEMP_W = 11,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TEMP_W-1:0] reg_wdata,
    output logic [TEMP_W-1:0] lim_high,
    output logic [TEMP_W-1:0] lim_low,
    output logic [TEMP_W-1:0] lim_crit,
    output logic [TEMP_W-1:0] crit_hyst,
    output evt_mode_e         mode_q,
    output logic              clr_pend,
    output logic              drop_pend
);
    localparam logic [TEMP_W-1:0] MAX_POS = {1'b0, {(TEMP_W-1){1'b1}}};
    localparam logic [TEMP_W-1:0] MIN_NEG = {1'b1, {(TEMP_W-1){1'b0}}};

    logic hit_ctrl;
    logic hit_mode;

    // Address decode for the strobe registers.
    always_comb begin
        hit_ctrl = reg_we && (reg_addr == ADDR_W'(RA_CTRL));
        hit_mode = reg_we && (reg_addr == ADDR_W'(RA_MODE));
    end

    // Clear and mode-leave strobes act at the write edge.
    always_comb begin
        clr_pend  = hit_ctrl && reg_wdata[0];
        drop_pend = hit_mode && (evt_mode_e'(reg_wdata[1:0]) != EVM_LATCH);
    end

    // Register storage with reset defaults that raise no event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_high  <= MAX_POS;
            lim_low   <= MIN_NEG;
            lim_crit  <= MAX_POS;
            crit_hyst <= '0;
            mode_q    <= EVM_WINDOW;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_W'(RA_HIGH): lim_high  <= reg_wdata;
                ADDR_W'(RA_LOW):  lim_low   <= reg_wdata;
                ADDR_W'(RA_CRIT): lim_crit  <= reg_wdata;
                ADDR_W'(RA_HYST): crit_hyst <= reg_wdata;
                ADDR_W'(RA_MODE): mode_q    <= evt_mode_e'(reg_wdata[1:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tevt_cmp.sv
// Module: tevt_cmp
// Compares each valid sample against the window and critical limits, and
// keeps the three status flags. Assumes signed two's complement samples
// and an unsigned hysteresis. Arithmetic is two bits wider, so the
// release threshold cannot wrap.
module tevt_cmp #(
    parameter int TEMP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_vld,
    input  logic [TEMP_W-1:0] temp_val,
    input  logic [TEMP_W-1:0] lim_high,
    input  logic [TEMP_W-1:0] lim_low,
    input  logic [TEMP_W-1:0] lim_crit,
    input  logic [TEMP_W-1:0] crit_hyst,
    output logic              win_now,
    output logic              st_hi,
    output logic              st_lo,
    output logic              st_crit
);
    localparam int EXT_W = TEMP_W + 2;

    logic signed [EXT_W-1:0] t_ext, hi_ext, lo_ext, cr_ext, rel_thr;
    logic hi_now, lo_now, cr_set, cr_rel;

    // Sign-extend operands and form the critical release threshold.
    always_comb begin
        t_ext   = EXT_W'($signed(temp_val));
        hi_ext  = EXT_W'($signed(lim_high));
        lo_ext  = EXT_W'($signed(lim_low));
        cr_ext  = EXT_W'($signed(lim_crit));
        rel_thr = cr_ext - $signed({2'b00, crit_hyst});
    end

    // Strict comparisons for the current sample.
    always_comb begin
        hi_now  = t_ext > hi_ext;
        lo_now  = t_ext < lo_ext;
        cr_set  = t_ext > cr_ext;
        cr_rel  = t_ext < rel_thr;
        win_now = temp_vld && (hi_now || lo_now);
    end

    // Status flags update only on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_hi   <= 1'b0;
            st_lo   <= 1'b0;
            st_crit <= 1'b0;
        end else if (temp_vld) begin
            st_hi <= hi_now;
            st_lo <= lo_now;
            if (cr_set)
                st_crit <= 1'b1;
            else if (cr_rel)
                st_crit <= 1'b0;
        end
    end
endmodule

// File: rtl/tevt_evt.sv
// Module: tevt_evt
// Forms the active-low event from the flags and the mode. It keeps the
// latched pending event for latched mode. Assumes the flags are
// registered, so event_n is glitch-free.
module tevt_evt
    import tevt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  evt_mode_e mode_q,
    input  logic      win_now,
    input  logic      clr_pend,
    input  logic      drop_pend,
    input  logic      st_hi,
    input  logic      st_lo,
    input  logic      st_crit,
    output logic      int_pend,
    output logic      event_n
);
    logic win_mode;

    // Window flags drive the event directly in window modes.
    always_comb begin
        win_mode = (mode_q == EVM_WINDOW) || (mode_q == EVM_WINDOW2);
    end

    // Pending event: a mode leave wins, then a new violation, then a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_pend <= 1'b0;
        else if (drop_pend)
            int_pend <= 1'b0;
        else if ((mode_q == EVM_LATCH) && win_now)
            int_pend <= 1'b1;
        else if (clr_pend)
            int_pend <= 1'b0;
    end

    // Combine the sources; the critical flag counts in every mode.
    always_comb begin
        event_n = !(int_pend || st_crit || (win_mode && (st_hi || st_lo)));
    end
endmodule

// File: rtl/temp_alarm_unit.sv
// Module: temp_alarm_unit
// Top of the temperature event comparator. It connects the register bank,
// the comparator and the event former. Assumes one sample per valid
// strobe and single-cycle register writes.
module temp_alarm_unit
    import tevt_pkg::*;
#(
    parameter int TEMP_W = 11,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_vld,
    input  logic [TEMP_W-1:0] temp_val,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TEMP_W-1:0] reg_wdata,
    output logic              event_n,
    output logic              flag_above_hi,
    output logic              flag_below_lo,
    output logic              flag_crit
);
    logic [TEMP_W-1:0] lim_high, lim_low, lim_crit, crit_hyst;
    evt_mode_e mode_q;
    logic clr_pend, drop_pend, win_now, int_pend;

    tevt_regs #(.TEMP_W(TEMP_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .lim_high(lim_high), .lim_low(lim_low),
        .lim_crit(lim_crit), .crit_hyst(crit_hyst), .mode_q(mode_q),
        .clr_pend(clr_pend), .drop_pend(drop_pend)
    );

    tevt_cmp #(.TEMP_W(TEMP_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_val(temp_val),
        .lim_high(lim_high), .lim_low(lim_low), .lim_crit(lim_crit),
        .crit_hyst(crit_hyst), .win_now(win_now), .st_hi(flag_above_hi),
        .st_lo(flag_below_lo), .st_crit(flag_crit)
    );

    tevt_evt u_evt (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .win_now(win_now),
        .clr_pend(clr_pend), .drop_pend(drop_pend), .st_hi(flag_above_hi),
        .st_lo(flag_below_lo), .st_crit(flag_crit), .int_pend(int_pend),
        .event_n(event_n)
    );
endmodule

// File: rtl/tevt_checker.sv
// Module: tevt_checker
// Property checks for temp_alarm_unit, attached with bind. Mode and
// pending state are taken from the top; strobes are decoded from ports.
module tevt_checker
    import tevt_pkg::*;
#(
    parameter int TEMP_W = 11,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              temp_vld,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [TEMP_W-1:0] reg_wdata,
    input evt_mode_e         mode_q,
    input logic              int_pend,
    input logic              event_n,
    input logic              flag_above_hi,
    input logic              flag_below_lo,
    input logic              flag_crit
);
    logic wr_clr, wr_mode;

    // Port-level decode of the clear and mode writes.
    always_comb begin
        wr_clr  = reg_we && (reg_addr == ADDR_W'(RA_CTRL)) && reg_wdata[0];
        wr_mode = reg_we && (reg_addr == ADDR_W'(RA_MODE));
    end

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_vld |=> $stable({flag_above_hi, flag_below_lo, flag_crit})); // R3
    AST_CRIT_RISE_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_crit) |-> $past(temp_vld)); // R5
    AST_WINDOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == EVM_WINDOW || mode_q == EVM_WINDOW2) &&
         !flag_above_hi && !flag_below_lo && !flag_crit) |-> event_n); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pend && !wr_clr && !wr_mode) |=> int_pend); // R7
    AST_PEND_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend |-> !event_n); // R7
    AST_CRIT_DRIVES_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_crit |-> !event_n); // R8
    AST_CRITONLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == EVM_CRITONLY && !flag_crit) |-> event_n); // R9
    AST_PEND_DROP_ON_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && reg_wdata[1:0] != 2'd0) |=> !int_pend); // R10
endmodule

bind temp_alarm_unit tevt_checker #(.TEMP_W(TEMP_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mode_q(mode_q),
    .int_pend(int_pend), .event_n(event_n), .flag_above_hi(flag_above_hi),
    .flag_below_lo(flag_below_lo), .flag_crit(flag_crit)
);

// File: tb/sim_temp_alarm_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected {event_n, hi, lo, crit}
// after each edge, and the monitor compares on the next falling edge.
module sim_temp_alarm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        temp_vld = 1'b0;
    logic [10:0] temp_val = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [10:0] reg_wdata = '0;
    logic        event_n, flag_above_hi, flag_below_lo, flag_crit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    temp_alarm_unit u0 (
        .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_val(temp_val),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .event_n(event_n), .flag_above_hi(flag_above_hi),
        .flag_below_lo(flag_below_lo), .flag_crit(flag_crit)
    );

    // Monitor: pop one expectation per falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t it;
                logic [3:0] act;
                it  = exp_q.pop_front();
                act = {event_n, flag_above_hi, flag_below_lo, flag_crit};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: {event_n,hi,lo,crit} actual %b expected %b",
                             it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver: apply one sample (or idle cycle) and queue its expected result.
    task automatic step(input bit v, input int t, input logic [3:0] e, input string tag);
        @(negedge clk);
        temp_vld = v;
        temp_val = 11'(t);
        @(posedge clk);
        exp_q.push_back('{exp: e, tag: tag});
        @(negedge clk);
        temp_vld = 1'b0;
    endtask

    // Register write; no sample is taken in this cycle.
    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = 11'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, no event, and the default limits raise nothing
        step(1'b0, 0, 4'b1000, "R1 reset");
        step(1'b1, 1023, 4'b1000, "R1 default limits at max code");
        // R2: program the limits
        wr(0, 100); wr(1, -20); wr(2, 200); wr(3, 10); wr(4, 1);
        step(1'b1, 50,   4'b1000, "R6 in window");
        step(1'b1, 150,  4'b0100, "R4/R6 above high");
        step(1'b0, -50,  4'b0100, "R3 no strobe holds");
        step(1'b1, 60,   4'b1000, "R6 self release");
        step(1'b1, -30,  4'b0010, "R4 below low");
        step(1'b1, -20,  4'b1000, "R4 equal low");
        step(1'b1, 100,  4'b1000, "R4 equal high");
        // Latched mode
        wr(4, 0);
        step(1'b1, 150,  4'b0100, "R7 latch set");
        step(1'b1, 50,   4'b0000, "R7 latch held");
        wr(5, 1);
        step(1'b1, 50,   4'b1000, "R7 cleared");
        step(1'b1, 250,  4'b0101, "R8 critical in latched mode");
        wr(5, 1);
        step(1'b0, 0,    4'b0101, "R8 clear does not release critical");
        step(1'b1, 50,   4'b1000, "R5 critical released");
        // Critical-only mode with hysteresis
        wr(4, 2);
        step(1'b1, 201,  4'b0101, "R5/R9 critical set");
        step(1'b1, 195,  4'b0101, "R5 in hysteresis band");
        step(1'b1, 190,  4'b0101, "R5 at release threshold");
        step(1'b1, 189,  4'b1100, "R9 window ignored after release");
        step(1'b1, 200,  4'b1100, "R5 equal critical");
        step(1'b1, 201,  4'b0101, "R5 critical again");
        step(1'b1, 50,   4'b1000, "R9 idle");
        // Leaving latched mode discards the pending event
        wr(4, 0);
        step(1'b1, 150,  4'b0100, "R7 latch set again");
        step(1'b1, 50,   4'b0000, "R7 held");
        wr(4, 3);
        step(1'b0, 0,    4'b1000, "R10 mode leave drops pending");
        step(1'b1, -40,  4'b0010, "R6 mode code 3 acts as window");
        step(1'b1, 0,    4'b1000, "R11 release one cycle after sample");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule